// File: doc/BRIEF.md
# Single-Lamp Serial Index Driver

This block drives the lamp ring of a roulette-style playfield. It has 37 index lamps, of which exactly one is lit once play has started, and a separate operator lamp. The processor first stores a lamp number in a holding register at one I/O address. Nothing visible changes at that point. A later write to the parallel output port commits the number: the lamp that was lit goes dark and the newly indexed lamp lights in the same cycle.

The same parallel write also carries an audio sample. The sample byte is mirrored bit for bit and then held on an 8-bit output that feeds an unsigned PCM DAC. A number that falls outside the lamp ring is never shown. Bit 7 of the stored number is dropped first. If the value is still too large, the lamp that is already lit stays lit, and that lamp number is written back into the holding register.

The operator lamp is independent of the index mechanism. It copies an input-scan condition, supplied on a side input, with one register stage of delay.

Top module: `lamp_index_driver`

## Requirements
- R1: While reset is asserted and after it is released, all 38 lamp outputs are 0 and the DAC output is 8'h80, until the first parallel-port write.
- R2: A write to address 8'h0B stores all 8 data bits in the holding register and changes no lamp output and no DAC output.
- R3: A write to address 8'hC0 (the parallel port) updates the lamps one clock later: the lamp at the resolved index is on, every other index lamp (bits 0 to 36) is off, and at most one index lamp is ever on.
- R4: Bit 7 of the held byte is cleared before the index is used, so a held value of 8'h8C lights lamp 12.
- R5: If the index, after bit 7 is cleared, is greater than 36, the lamp that is already lit stays lit. Index 36 is accepted and index 37 is rejected.
- R6: The resolved index is written back into the holding register, so a second parallel-port write with no new holding write keeps the same lamp lit.
- R7: The DAC output takes the bit-reversed parallel-port data (data bit i goes to DAC bit 7-i) one clock after the write, and holds that value until the next parallel-port write.
- R8: Lamp output bit 37 equals the operator-scan input as sampled at the previous clock edge, and the index mechanism never drives it.
- R9: Writes to any address other than 8'h0B and 8'hC0 change neither the holding register, the lamps nor the DAC output.
- R10: After reset the held index is 0, so a parallel-port write issued before any holding write lights lamp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 8 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| op_scan | input | 1 | Operator-lamp condition from the input scan |
| lamps | output | 38 | Bits 0 to 36 are index lamps, bit 37 is the operator lamp |
| dac_out | output | 8 | Unsigned PCM sample for the DAC |

## Verification
The assertions assume that each write strobe lasts one cycle and carries a single address, so the holding write and the parallel-port write never land in the same cycle. They also assume that the inputs are stable at the sampling edge. The bench drives every input on the falling edge and pulses io_wr for exactly one cycle per write, so it stays within these assumptions. It reaches the range limit from both sides and uses held values with and without bit 7 set. It also uses neighbouring addresses that must be ignored.

// File: rtl/lamp_pkg.sv
// Package: shared byte type and the bit-mirroring helper used by the
// lamp index driver. It assumes 8-bit I/O data throughout.
package lamp_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] io_byte_t;

    // Mirror a byte: bit i moves to bit BYTE_W-1-i.
    function automatic io_byte_t mirror_byte(input io_byte_t b);
        io_byte_t r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/lamp_hold_reg.sv
// Holding register for the lamp number.
// It loads the full byte on a holding write. On a commit it resolves the index:
// bit 7 is cleared, and a value past the last lamp falls back to the current
// lamp. The resolved index is stored back into the register.
// Assumes load and commit are never asserted in the same cycle.
module lamp_hold_reg
    import lamp_pkg::*;
#(
    parameter int LAMP_CNT = 37,
    localparam int IDX_W  = $clog2(LAMP_CNT),
    localparam int PAD_W  = BYTE_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  io_byte_t         load_data,
    input  logic             commit,
    input  logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] next_idx
);

    localparam int LAST_IDX = LAMP_CNT - 1;

    io_byte_t held_q;
    io_byte_t stripped;
    logic     in_range;

    // Drop bit 7 and range-check the remaining value.
    always_comb begin
        stripped = {1'b0, held_q[BYTE_W-2:0]};
        in_range = (int'(stripped) <= LAST_IDX);
        next_idx = in_range ? stripped[IDX_W-1:0] : cur_idx;
    end

    // Capture the raw byte on load; store the resolved index back on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (load) begin
            held_q <= load_data;
        end else if (commit) begin
            held_q <= {{PAD_W{1'b0}}, next_idx};
        end
    end

endmodule

// File: rtl/lamp_onehot.sv
// Current-lamp register and one-hot lamp decoder.
// On commit it takes the resolved index. Lamps stay dark until the first
// commit after reset. Assumes new_idx is always below LAMP_CNT.
module lamp_onehot #(
    parameter int LAMP_CNT = 37,
    localparam int IDX_W  = $clog2(LAMP_CNT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [IDX_W-1:0]    new_idx,
    output logic [IDX_W-1:0]    cur_idx,
    output logic [LAMP_CNT-1:0] lamp_vec
);

    logic             armed_q;
    logic [IDX_W-1:0] cur_q;

    // Track the lit lamp and whether any commit has happened yet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            armed_q <= 1'b0;
        end else if (commit) begin
            cur_q   <= new_idx;
            armed_q <= 1'b1;
        end
    end

    assign cur_idx = cur_q;

    // One comparator per lamp drives its output.
    for (genvar g = 0; g < LAMP_CNT; g++) begin : g_lamp
        assign lamp_vec[g] = armed_q && (cur_q == IDX_W'(g));
    end

endmodule

// File: rtl/lamp_dac_reg.sv
// DAC sample register: stores the mirrored byte of each parallel-port write
// and holds it between writes. Resets to mid-scale.
module lamp_dac_reg
    import lamp_pkg::*;
#(
    parameter io_byte_t DAC_RST = 8'h80
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     commit,
    input  io_byte_t sample_in,
    output io_byte_t dac_q
);

    // Register the mirrored sample on each commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_q <= DAC_RST;
        end else if (commit) begin
            dac_q <= mirror_byte(sample_in);
        end
    end

endmodule

// File: rtl/lamp_index_driver.sv
// Top: decodes the I/O writes and drives the lamp ring, the operator lamp and
// the DAC byte. A write to HOLD_ADDR loads the lamp number. A write to
// PORT_ADDR commits the lamp number and carries the sample.
// Assumes one address per write strobe.
module lamp_index_driver
    import lamp_pkg::*;
#(
    parameter int       LAMP_CNT  = 37,
    parameter io_byte_t HOLD_ADDR = 8'h0B,
    parameter io_byte_t PORT_ADDR = 8'hC0,
    parameter io_byte_t DAC_RST   = 8'h80,
    localparam int      IDX_W     = $clog2(LAMP_CNT),
    localparam int      OUT_CNT   = LAMP_CNT + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic [7:0]         io_addr,
    input  logic [7:0]         io_wdata,
    input  logic               op_scan,
    output logic [OUT_CNT-1:0] lamps,
    output logic [7:0]         dac_out
);

    logic             hold_wr;
    logic             port_wr;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] next_idx;
    logic [LAMP_CNT-1:0] idx_lamps;
    logic             op_lamp_q;

    // Decode the two addresses the block responds to.
    always_comb begin
        hold_wr = io_wr && (io_addr == HOLD_ADDR);
        port_wr = io_wr && (io_addr == PORT_ADDR);
    end

    lamp_hold_reg #(.LAMP_CNT(LAMP_CNT)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (hold_wr),
        .load_data (io_wdata),
        .commit    (port_wr),
        .cur_idx   (cur_idx),
        .next_idx  (next_idx)
    );

    lamp_onehot #(.LAMP_CNT(LAMP_CNT)) u_onehot (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (port_wr),
        .new_idx  (next_idx),
        .cur_idx  (cur_idx),
        .lamp_vec (idx_lamps)
    );

    lamp_dac_reg #(.DAC_RST(DAC_RST)) u_dac (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (port_wr),
        .sample_in (io_wdata),
        .dac_q     (dac_out)
    );

    // Register the operator-lamp scan condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_lamp_q <= 1'b0;
        end else begin
            op_lamp_q <= op_scan;
        end
    end

    assign lamps = {op_lamp_q, idx_lamps};

endmodule

// File: rtl/lamp_index_driver_chk.sv
// Checker for lamp_index_driver. It observes only the ports and is attached
// with the bind statement at the end of this file.
module lamp_index_driver_chk #(
    parameter int         LAMP_CNT  = 37,
    parameter logic [7:0] PORT_ADDR = 8'hC0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic [7:0]        io_addr,
    input logic [7:0]        io_wdata,
    input logic              op_scan,
    input logic [LAMP_CNT:0] lamps,
    input logic [7:0]        dac_out
);

    logic port_wr;
    assign port_wr = io_wr && (io_addr == PORT_ADDR);

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = b[i];
        return r;
    endfunction

    assert_onehot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lamps[LAMP_CNT-1:0]));

    assert_commit_lit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> ($countones(lamps[LAMP_CNT-1:0]) == 1));

    assert_lamps_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(lamps[LAMP_CNT-1:0]));

    assert_dac_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> (dac_out == rev8($past(io_wdata))));

    assert_dac_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(dac_out));

    assert_op_lamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lamps[LAMP_CNT] == $past(op_scan)));

endmodule

bind lamp_index_driver lamp_index_driver_chk #(
    .LAMP_CNT  (LAMP_CNT),
    .PORT_ADDR (PORT_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .op_scan  (op_scan),
    .lamps    (lamps),
    .dac_out  (dac_out)
);

// File: tb/lamp_index_driver_bench.sv
module lamp_index_driver_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        op_scan = 1'b0;
    logic [37:0] lamps;
    logic [7:0]  dac_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lamp_index_driver u_lamp_index_driver (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .op_scan  (op_scan),
        .lamps    (lamps),
        .dac_out  (dac_out)
    );

    function automatic logic [7:0] mirror(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = b[i];
        return r;
    endfunction

    // One-cycle write, driven on the falling edge; returns on the falling
    // edge after the capturing rising edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 8'h00; io_wdata = 8'h00;
    endtask

    task automatic check_idx(input int exp_idx, input string req);
        logic [36:0] exp_v;
        exp_v = '0;
        if (exp_idx >= 0) exp_v[exp_idx] = 1'b1;
        checks++;
        if (lamps[36:0] !== exp_v) begin
            failures++;
            $display("FAIL %s index lamps actual=%h expected=%h", req, lamps[36:0], exp_v);
        end
    endtask

    task automatic check_op(input logic exp, input string req);
        checks++;
        if (lamps[37] !== exp) begin
            failures++;
            $display("FAIL %s operator lamp actual=%b expected=%b", req, lamps[37], exp);
        end
    endtask

    task automatic check_dac(input logic [7:0] exp, input string req);
        checks++;
        if (dac_out !== exp) begin
            failures++;
            $display("FAIL %s dac actual=%h expected=%h", req, dac_out, exp);
        end
    endtask

    task automatic t_reset_R1;
        @(negedge clk);
        check_idx(-1, "R1");
        check_op(1'b0, "R1");
        check_dac(8'h80, "R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idx(-1, "R1");
        check_dac(8'h80, "R1");
    endtask

    task automatic t_first_commit_R10;
        wr(8'hC0, 8'h00);
        check_idx(0, "R10");
        check_dac(8'h00, "R10");
    endtask

    task automatic t_hold_then_commit_R2_R3;
        wr(8'h0B, 8'h05);
        check_idx(0, "R2");
        check_dac(8'h00, "R2");
        wr(8'hC0, 8'h01);
        check_idx(5, "R3");
        check_dac(8'h80, "R7");
    endtask

    task automatic t_bit7_R4;
        wr(8'h0B, 8'h8C);
        wr(8'hC0, 8'hF0);
        check_idx(12, "R4");
        check_dac(8'h0F, "R7");
    endtask

    task automatic t_range_R5;
        wr(8'h0B, 8'd36);
        wr(8'hC0, 8'h12);
        check_idx(36, "R5");
        check_dac(mirror(8'h12), "R7");
        wr(8'h0B, 8'd37);
        wr(8'hC0, 8'h0E);
        check_idx(36, "R5");
        check_op(1'b0, "R8");
        wr(8'h0B, 8'hA5);
        wr(8'hC0, 8'hC3);
        check_idx(36, "R5");
        wr(8'h0B, 8'hFF);
        wr(8'hC0, 8'h3C);
        check_idx(36, "R5");
        wr(8'h0B, 8'hA4);
        wr(8'hC0, 8'h3C);
        check_idx(36, "R5");
    endtask

    task automatic t_writeback_R6;
        wr(8'h0B, 8'd7);
        wr(8'hC0, 8'h00);
        check_idx(7, "R6");
        wr(8'hC0, 8'h00);
        check_idx(7, "R6");
        wr(8'h0B, 8'd40);
        wr(8'hC0, 8'h00);
        check_idx(7, "R6");
        wr(8'hC0, 8'h00);
        check_idx(7, "R6");
    endtask

    task automatic t_ignore_R9;
        wr(8'hC0, 8'h12);
        check_dac(8'h48, "R7");
        wr(8'h0C, 8'd3);
        wr(8'h0A, 8'd4);
        wr(8'hC1, 8'h55);
        wr(8'hBF, 8'h55);
        check_idx(7, "R9");
        check_dac(8'h48, "R9");
        wr(8'hC0, 8'h01);
        check_idx(7, "R9");
        check_dac(8'h80, "R9");
    endtask

    task automatic t_dac_hold_R7;
        repeat (5) @(negedge clk);
        check_dac(8'h80, "R7");
        wr(8'h0B, 8'd20);
        check_dac(8'h80, "R7");
        wr(8'hC0, 8'h0E);
        check_dac(8'h70, "R7");
        check_idx(20, "R3");
    endtask

    task automatic t_op_lamp_R8;
        op_scan = 1'b1;
        @(negedge clk);
        check_op(1'b1, "R8");
        check_idx(20, "R8");
        wr(8'h0B, 8'd2);
        wr(8'hC0, 8'h00);
        check_op(1'b1, "R8");
        check_idx(2, "R8");
        op_scan = 1'b0;
        @(negedge clk);
        check_op(1'b0, "R8");
        check_idx(2, "R8");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        t_reset_R1();
        t_first_commit_R10();
        t_hold_then_commit_R2_R3();
        t_bit7_R4();
        t_range_R5();
        t_writeback_R6();
        t_ignore_R9();
        t_dac_hold_R7();
        t_op_lamp_R8();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule